// File: doc/BRIEF.md
# Memory-Mapped Device Select Decoder

This block is the glue between a processor's address/data bus and five memory-mapped peripherals: four display quadrant controllers and one infrared receive interface. It splits the 16-bit address word into three fields. The top bit is a one-bit I/O prefix. Bits 10 down to 6 form a one-hot device-select field with one bit per device. The low address bits form a device-control field. The block produces each device's enable guard by gating the data strobe with that device's address match. It drives the device control pins straight from the low address bits, so a single load can set them and read data in the same access. The write data bus fans out to every device, and read data returns from the selected device only.

A bus transaction has an address cycle followed by a data cycle. The address stays valid through both, and the actual read or write takes place on the strobe pulse within the data cycle. The block is purely combinational. A device enable follows the strobe with no clock latency, so it rises and falls inside the processor's own strobe window.

Top module: `mmio_sel_decoder`

## Requirements
- R1: When address bit 15 is 1 (not an I/O access), no device enable is asserted, no device data driver is enabled, and `bus_rdata` is 0.
- R2: With address bit 15 at 0, the strobe high and exactly one of address bits 10..6 set, the enable for device i is asserted, where i is the set bit minus 6. Devices 0..3 are the display quadrants and device 4 is the infrared interface. All other enables stay low.
- R3: If the select field (address bits 10..6) has no bit set, or more than one bit set, no device enable is asserted.
- R4: No device enable is ever asserted while `bus_strobe` is low, whatever the address.
- R5: `disp_rs` always equals address bit 1 and `disp_rw` always equals address bit 0, whether or not any device is selected.
- R6: `ir_ctl` always equals address bits 5..0.
- R7: `dev_wdata` always equals `bus_wdata`. A bit of `dev_wdrive` is 1 only when the matching device enable is 1 and `bus_we` is 1.
- R8: When a device is enabled and `bus_we` is 0, `bus_rdata` equals that device's 8-bit slice of `dev_rdata` (bits 8i+7..8i for device i). In every other case `bus_rdata` is 0.
- R9: Address bits 14..11 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 16 | Processor address word |
| bus_wdata | input | 8 | Processor write data |
| bus_we | input | 1 | 1 for a store, 0 for a load |
| bus_strobe | input | 1 | Data strobe, high during the transfer pulse |
| bus_rdata | output | 8 | Read data returned to the processor |
| dev_rdata | input | 40 | Read data from each device, 8 bits per device |
| dev_en | output | 5 | Enable guard for each device |
| dev_wdrive | output | 5 | Per-device write data driver enable |
| dev_wdata | output | 8 | Write data fanned out to all devices |
| disp_rs | output | 1 | Display register-select line |
| disp_rw | output | 1 | Display read/write line |
| ir_ctl | output | 6 | Infrared interface control inputs |

## Verification
The block holds no state, so a wrong decode appears at the ports within the same evaluation as the address and strobe that cause it. There is no delay before it shows and nothing for it to hide behind. The dangerous faults are an enable that ignores the prefix, the strobe or a malformed select field. Such a fault shows as two guards at once or a guard outside the strobe window, and it would corrupt a peripheral register on a memory access. A wrong read mux shows as data from an unselected device, or as non-zero read data on an idle bus.

// File: rtl/mmio_sel_decoder.sv
module mmio_sel_decoder #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int N_DEV   = 5,
  parameter int SEL_LSB = 6,
  parameter int CTL_W   = 6
) (
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_we,
  input  logic                    bus_strobe,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N_DEV*DATA_W-1:0] dev_rdata,
  output logic [N_DEV-1:0]        dev_en,
  output logic [N_DEV-1:0]        dev_wdrive,
  output logic [DATA_W-1:0]       dev_wdata,
  output logic                    disp_rs,
  output logic                    disp_rw,
  output logic [CTL_W-1:0]        ir_ctl
);

  localparam int PFX_BIT = ADDR_W - 1;

  logic             io_hit;
  logic [N_DEV-1:0] sel;
  logic             sel_ok;

  assign io_hit = ~bus_addr[PFX_BIT];
  assign sel    = bus_addr[SEL_LSB +: N_DEV];
  assign sel_ok = (sel != '0) && ((sel & (sel - N_DEV'(1))) == '0);

  assign dev_en     = (io_hit && sel_ok && bus_strobe) ? sel : '0;
  assign dev_wdrive = bus_we ? dev_en : '0;
  assign dev_wdata  = bus_wdata;

  assign disp_rs = bus_addr[1];
  assign disp_rw = bus_addr[0];
  assign ir_ctl  = bus_addr[CTL_W-1:0];

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_DEV; i++)
      if (dev_en[i] && !bus_we)
        bus_rdata = bus_rdata | dev_rdata[i*DATA_W +: DATA_W];
  end

  always_comb begin
    p_en_onehot_r3: assert ($onehot0(dev_en))
      else $error("more than one device enabled");
    if (!bus_strobe)
      p_en_needs_strobe_r4: assert (dev_en == '0)
        else $error("enable outside strobe");
    if (bus_addr[PFX_BIT])
      p_prefix_blocks_r1: assert (dev_en == '0 && dev_wdrive == '0)
        else $error("enable on non-I/O access");
    p_drive_within_en_r7: assert ((dev_wdrive & ~dev_en) == '0)
      else $error("driver on unselected device");
    if (dev_en == '0)
      p_rdata_idle_r8: assert (bus_rdata == '0)
        else $error("read data with no device selected");
  end

endmodule

// File: tb/sim_mmio_sel_decoder.sv
module sim_mmio_sel_decoder;
  logic        clk = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        bus_strobe;
  logic [7:0]  bus_rdata;
  logic [39:0] dev_rdata;
  logic [4:0]  dev_en;
  logic [4:0]  dev_wdrive;
  logic [7:0]  dev_wdata;
  logic        disp_rs;
  logic        disp_rw;
  logic [5:0]  ir_ctl;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mmio_sel_decoder u0 (
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_strobe(bus_strobe), .bus_rdata(bus_rdata), .dev_rdata(dev_rdata),
    .dev_en(dev_en), .dev_wdrive(dev_wdrive), .dev_wdata(dev_wdata),
    .disp_rs(disp_rs), .disp_rw(disp_rw), .ir_ctl(ir_ctl)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [7:0] wd, input logic we, input logic stb);
    @(negedge clk);
    bus_addr = a; bus_wdata = wd; bus_we = we; bus_strobe = stb;
    #2;
  endtask

  task automatic t_idle;
    drive(16'h0000, 8'h00, 1'b0, 1'b0);
    chk("R4 idle en", {11'd0, dev_en}, 16'h0);
    chk("R8 idle rdata", {8'd0, bus_rdata}, 16'h0);
  endtask

  task automatic t_select_each;
    for (int i = 0; i < 5; i++) begin
      drive(16'(1 << (6 + i)), 8'h3C + 8'(i), 1'b1, 1'b1);
      chk("R2 one-hot enable", {11'd0, dev_en}, 16'(1 << i));
      chk("R7 write driver", {11'd0, dev_wdrive}, 16'(1 << i));
      chk("R7 write data", {8'd0, dev_wdata}, {8'd0, 8'h3C + 8'(i)});
    end
  endtask

  task automatic t_read_each;
    for (int i = 0; i < 5; i++) begin
      drive(16'(1 << (6 + i)) | 16'h0002, 8'hFF, 1'b0, 1'b1);
      chk("R8 read mux", {8'd0, bus_rdata}, {8'd0, 8'hA0 + 8'(i)});
      chk("R7 no driver on read", {11'd0, dev_wdrive}, 16'h0);
    end
  endtask

  task automatic t_prefix;
    drive(16'h8040, 8'h11, 1'b1, 1'b1);
    chk("R1 prefix write en", {11'd0, dev_en}, 16'h0);
    chk("R1 prefix driver", {11'd0, dev_wdrive}, 16'h0);
    drive(16'h8400, 8'h11, 1'b0, 1'b1);
    chk("R1 prefix read data", {8'd0, bus_rdata}, 16'h0);
  endtask

  task automatic t_bad_select;
    drive(16'h00C0, 8'h00, 1'b0, 1'b1);
    chk("R3 two select bits", {11'd0, dev_en}, 16'h0);
    chk("R3 two bits rdata", {8'd0, bus_rdata}, 16'h0);
    drive(16'h07C0, 8'h00, 1'b0, 1'b1);
    chk("R3 all select bits", {11'd0, dev_en}, 16'h0);
    drive(16'h003F, 8'h00, 1'b0, 1'b1);
    chk("R3 no select bit", {11'd0, dev_en}, 16'h0);
  endtask

  task automatic t_strobe;
    drive(16'h0100, 8'h55, 1'b1, 1'b0);
    chk("R4 strobe low", {11'd0, dev_en}, 16'h0);
    drive(16'h0100, 8'h55, 1'b1, 1'b1);
    chk("R4 strobe high", {11'd0, dev_en}, 16'h0004);
    drive(16'h0100, 8'h55, 1'b1, 1'b0);
    chk("R4 strobe fall", {11'd0, dev_en}, 16'h0);
  endtask

  task automatic t_ctl;
    for (int v = 0; v < 64; v += 21) begin
      drive(16'h8000 | 16'(v), 8'h00, 1'b0, 1'b0);
      chk("R5 rs", {15'd0, disp_rs}, {15'd0, 1'(v >> 1)});
      chk("R5 rw", {15'd0, disp_rw}, {15'd0, 1'(v)});
      chk("R6 ir ctl", {10'd0, ir_ctl}, 16'(v));
    end
  endtask

  task automatic t_free_bits;
    drive(16'h7880 | 16'h0001, 8'h00, 1'b0, 1'b1);
    chk("R9 free bits en", {11'd0, dev_en}, 16'h0002);
    chk("R9 free bits rdata", {8'd0, bus_rdata}, 16'h00A1);
    chk("R9 free bits rw", {15'd0, disp_rw}, 16'h1);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_strobe = 1'b0;
    for (int i = 0; i < 5; i++) dev_rdata[i*8 +: 8] = 8'hA0 + 8'(i);
    t_idle();
    t_select_each();
    t_read_each();
    t_prefix();
    t_bad_select();
    t_strobe();
    t_ctl();
    t_free_bits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule